// File: doc/BRIEF.md
# Digital RGB to Composite Video Encoder

This block turns a stream of unsigned red, green and blue samples into signed luma, chroma and composite video samples. It runs at a sample rate of four times the color subcarrier. Fixed-point matrices form the brightness signal Y and the two color-difference signals U and V. A quadrature subcarrier then modulates U and V. That subcarrier comes straight from a two-bit phase counter, so one carrier cycle spans exactly four samples.

Timing comes from outside the block. A sync level input replaces luma with the sync tip level of the selected standard. A burst gate input replaces the color-difference signals with the color-burst vector. In the 625-line standard (PAL), a line toggle input flips the sign of the V carrier on alternate lines. A standard select input chooses between the 525-line standard (NTSC) and PAL. Filtering, the luma trap and conversion to analog are handled outside the block.

Top module: `rgb_composite_enc`

## Requirements
- R1: While rst_n is low, luma_out, chroma_out and comp_out are all 0.
- R2: The block has a latency of two clock edges from capture to output. Outside sync, luma_out equals Y = (306·R + 601·G + 117·B + 512) >> 10 for the default 10-bit fractions. The coefficients sum to 1024, so full-scale RGB (255) gives Y = 255.
- R3: U = floor((505·(B − Y) + 512) / 1024) and V = floor((898·(R − Y) + 512) / 1024).
- R4: The phase counter gives 0 to the first sample captured after reset and then advances by one per sample, modulo 4. Chroma is +V, +U, −V, −U for phases 0, 1, 2, 3. This follows from a sine carrier of 0, +1, 0, −1 and a cosine carrier of +1, 0, −1, 0.
- R5: A grey input (R = G = B) outside sync and outside the burst gate gives chroma 0 at every phase.
- R6: With sync_lvl = 1, luma is −102 when std_pal = 0 (40 IRE of a 255 full scale) and −107 when std_pal = 1 (300 mV of 714 mV). Chroma is 0, and the RGB inputs are ignored.
- R7: With burst_gate = 1, sync_lvl = 0 and std_pal = 0, U = −102 and V = 0, which puts the burst at 180 degrees. RGB is ignored.
- R8: With burst_gate = 1, sync_lvl = 0 and std_pal = 1, U = −76 and V = +76 before the V carrier sign is applied, which puts the burst at 135 or 225 degrees.
- R9: With std_pal = 1, the V carrier is negated while line_tgl = 1, so each change of line_tgl inverts it. With std_pal = 0, line_tgl has no effect.
- R10: comp_out equals luma_out plus chroma_out, saturated to the signed OUT_W range.
- R11: When sync_lvl and burst_gate are both 1, sync takes priority: chroma is 0 and luma is at the sync level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock at four times the subcarrier |
| rst_n | input | 1 | Asynchronous active-low reset |
| red | input | IN_W | Red sample, unsigned |
| green | input | IN_W | Green sample, unsigned |
| blue | input | IN_W | Blue sample, unsigned |
| sync_lvl | input | 1 | 1 drives luma to the sync tip |
| burst_gate | input | 1 | 1 inserts the burst vector in place of U and V |
| line_tgl | input | 1 | Line alternation input for the PAL V sign |
| std_pal | input | 1 | 0 selects NTSC, 1 selects PAL |
| luma_out | output | OUT_W | Signed luma sample |
| chroma_out | output | OUT_W | Signed chroma sample |
| comp_out | output | OUT_W | Signed composite sample |

## Verification
Checker properties cover the following on every cycle:
- all outputs are zero during reset;
- chroma is zero two samples after any sync or grey input;
- the NTSC sync tip depth;
- during an NTSC burst, chroma stays on the U axis (0 or ±102).

The scenarios in the testbench cover the rest:
- exact matrix values for specific colors;
- the order of the four carrier phases;
- the PAL burst components;
- V sign reversal under the line toggle;
- the composite sum.

Each of these needs a known input history and a reference model.

// File: rtl/enc_pkg.sv
package enc_pkg;
   // rounded Q-format coefficient from a value given in thousandths
   function automatic int coef(input int milli, input int frac);
      return (milli * (1 << frac) + 500) / 1000;
   endfunction

   function automatic int full_scale(input int in_w);
      return (1 << in_w) - 1;
   endfunction

   // 40 IRE below black on a 100 IRE full scale
   function automatic int ntsc_sync_depth(input int in_w);
      return (full_scale(in_w) * 40 + 50) / 100;
   endfunction

   // 300 mV below black on a 714 mV full scale
   function automatic int pal_sync_depth(input int in_w);
      return (full_scale(in_w) * 300 + 357) / 714;
   endfunction

   // each burst component is the resultant divided by sqrt(2)
   function automatic int pal_burst_part(input int in_w);
      return (pal_sync_depth(in_w) * 724 + 512) / 1024;
   endfunction
endpackage

// File: rtl/enc_matrix.sv
module enc_matrix
   import enc_pkg::*;
#(
   parameter int IN_W = 8,
   parameter int FRAC = 10
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IN_W-1:0]        red,
   input  logic [IN_W-1:0]        green,
   input  logic [IN_W-1:0]        blue,
   output logic [IN_W-1:0]        y_q,
   output logic signed [IN_W:0]   u_q,
   output logic signed [IN_W:0]   v_q
);
   localparam int KR   = coef(299, FRAC);
   localparam int KB   = coef(114, FRAC);
   localparam int KG   = (1 << FRAC) - KR - KB;   // R2: coefficients sum to one
   localparam int KU   = coef(493, FRAC);
   localparam int KV   = coef(877, FRAC);
   localparam int HALF = 1 << (FRAC - 1);

   logic [IN_W-1:0]      y_n;
   logic signed [IN_W:0] u_n, v_n;
   int                   acc_y, diff_u, diff_v;

   always_comb begin
      acc_y  = KR * int'(red) + KG * int'(green) + KB * int'(blue);
      y_n    = IN_W'((acc_y + HALF) >>> FRAC);
      diff_u = int'(blue) - int'(y_n);
      diff_v = int'(red) - int'(y_n);
      u_n    = (IN_W+1)'((KU * diff_u + HALF) >>> FRAC);   // R3
      v_n    = (IN_W+1)'((KV * diff_v + HALF) >>> FRAC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_q <= '0;
         u_q <= '0;
         v_q <= '0;
      end else begin
         y_q <= y_n;
         u_q <= u_n;
         v_q <= v_n;
      end
   end
endmodule

// File: rtl/enc_quad_mod.sv
module enc_quad_mod
   import enc_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 12
) (
   input  logic [IN_W-1:0]          y,
   input  logic signed [IN_W:0]     u,
   input  logic signed [IN_W:0]     v,
   input  logic                     sync,
   input  logic                     gate,
   input  logic                     pal,
   input  logic                     flip,
   input  logic [1:0]               phase,
   output logic signed [OUT_W-1:0]  luma_n,
   output logic signed [OUT_W-1:0]  chroma_n
);
   localparam int NSYNC = ntsc_sync_depth(IN_W);
   localparam int PSYNC = pal_sync_depth(IN_W);
   localparam int PBURST = pal_burst_part(IN_W);

   int l_val, u_sel, v_sel, v_car, c_val;

   always_comb begin
      // R6 / R11: sync overrides burst and video
      if (sync) begin
         l_val = pal ? -PSYNC : -NSYNC;
         u_sel = 0;
         v_sel = 0;
      end else begin
         l_val = int'(y);
         if (gate) begin
            u_sel = pal ? -PBURST : -NSYNC;   // R7 / R8
            v_sel = pal ? PBURST : 0;
         end else begin
            u_sel = int'(u);
            v_sel = int'(v);
         end
      end
      // R9: PAL line alternation of the V carrier
      v_car = (pal && flip) ? -v_sel : v_sel;
      // R4: sine 0,+1,0,-1 on U; cosine +1,0,-1,0 on V
      unique case (phase)
         2'd0:    c_val = v_car;
         2'd1:    c_val = u_sel;
         2'd2:    c_val = -v_car;
         default: c_val = -u_sel;
      endcase
      luma_n   = OUT_W'(l_val);
      chroma_n = OUT_W'(c_val);
   end
endmodule

// File: rtl/enc_sum_sat.sv
module enc_sum_sat #(
   parameter int OUT_W    = 12,
   parameter bit NEED_SAT = 1'b1
) (
   input  logic signed [OUT_W-1:0] a,
   input  logic signed [OUT_W-1:0] b,
   output logic signed [OUT_W-1:0] s
);
   localparam logic signed [OUT_W:0] MAXV = (OUT_W+1)'((1 << (OUT_W-1)) - 1);
   localparam logic signed [OUT_W:0] MINV = -MAXV - 1;

   logic signed [OUT_W:0] wide;
   assign wide = {a[OUT_W-1], a} + {b[OUT_W-1], b};

   generate
      if (NEED_SAT) begin : g_sat
         // R10: clamp to the signed output range
         always_comb begin
            if (wide > MAXV)      s = MAXV[OUT_W-1:0];
            else if (wide < MINV) s = MINV[OUT_W-1:0];
            else                  s = wide[OUT_W-1:0];
         end
      end else begin : g_wide
         assign s = wide[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rgb_composite_enc.sv
module rgb_composite_enc #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 12,
   parameter int FRAC  = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IN_W-1:0]          red,
   input  logic [IN_W-1:0]          green,
   input  logic [IN_W-1:0]          blue,
   input  logic                     sync_lvl,
   input  logic                     burst_gate,
   input  logic                     line_tgl,
   input  logic                     std_pal,
   output logic signed [OUT_W-1:0]  luma_out,
   output logic signed [OUT_W-1:0]  chroma_out,
   output logic signed [OUT_W-1:0]  comp_out
);
   // sum of luma and chroma fits in IN_W+2 signed bits
   localparam bit NEED_SAT = (OUT_W < IN_W + 2);

   generate
      if (IN_W < 4 || IN_W > 12) begin : g_bad_in
         $error("rgb_composite_enc: IN_W out of range");
      end
      if (OUT_W < IN_W + 1) begin : g_bad_out
         $error("rgb_composite_enc: OUT_W too narrow for luma");
      end
      if (FRAC < 8 || FRAC + IN_W > 28) begin : g_bad_frac
         $error("rgb_composite_enc: FRAC out of range");
      end
   endgenerate

   logic [1:0] phase_q, s1_phase;
   logic       s1_sync, s1_gate, s1_pal, s1_flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= 2'd0;
         s1_phase <= 2'd0;
         s1_sync  <= 1'b0;
         s1_gate  <= 1'b0;
         s1_pal   <= 1'b0;
         s1_flip  <= 1'b0;
      end else begin
         phase_q  <= phase_q + 2'd1;   // R4
         s1_phase <= phase_q;
         s1_sync  <= sync_lvl;
         s1_gate  <= burst_gate;
         s1_pal   <= std_pal;
         s1_flip  <= line_tgl;
      end
   end

   logic [IN_W-1:0]         y_q;
   logic signed [IN_W:0]    u_q, v_q;
   logic signed [OUT_W-1:0] luma_n, chroma_n, comp_n;

   enc_matrix #(.IN_W(IN_W), .FRAC(FRAC)) u_matrix (
      .clk   (clk),
      .rst_n (rst_n),
      .red   (red),
      .green (green),
      .blue  (blue),
      .y_q   (y_q),
      .u_q   (u_q),
      .v_q   (v_q)
   );

   enc_quad_mod #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mod (
      .y        (y_q),
      .u        (u_q),
      .v        (v_q),
      .sync     (s1_sync),
      .gate     (s1_gate),
      .pal      (s1_pal),
      .flip     (s1_flip),
      .phase    (s1_phase),
      .luma_n   (luma_n),
      .chroma_n (chroma_n)
   );

   enc_sum_sat #(.OUT_W(OUT_W), .NEED_SAT(NEED_SAT)) u_sum (
      .a (luma_n),
      .b (chroma_n),
      .s (comp_n)
   );

   // R1: all outputs clear on reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         luma_out   <= '0;
         chroma_out <= '0;
         comp_out   <= '0;
      end else begin
         luma_out   <= luma_n;
         chroma_out <= chroma_n;
         comp_out   <= comp_n;
      end
   end
endmodule

// File: rtl/rgb_composite_enc_chk.sv
module rgb_composite_enc_chk
   import enc_pkg::*;
#(
   parameter int IN_W  = 8,
   parameter int OUT_W = 12,
   parameter int FRAC  = 10
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [IN_W-1:0]          red,
   input logic [IN_W-1:0]          green,
   input logic [IN_W-1:0]          blue,
   input logic                     sync_lvl,
   input logic                     burst_gate,
   input logic                     std_pal,
   input logic signed [OUT_W-1:0]  luma_out,
   input logic signed [OUT_W-1:0]  chroma_out,
   input logic signed [OUT_W-1:0]  comp_out
);
   localparam logic signed [OUT_W-1:0] NS_POS = OUT_W'(ntsc_sync_depth(IN_W));
   localparam logic signed [OUT_W-1:0] NS_NEG = OUT_W'(-ntsc_sync_depth(IN_W));

   a_r1_reset_zero: assert property (@(posedge clk)
      !rst_n |-> (luma_out == '0 && chroma_out == '0 && comp_out == '0));

   a_r6_sync_no_chroma: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lvl |=> ##1 (chroma_out == '0));

   a_r6_ntsc_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_lvl && !std_pal) |=> ##1 (luma_out == NS_NEG));

   a_r5_grey_no_chroma: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_lvl && !burst_gate && red == green && green == blue) |=> ##1 (chroma_out == '0));

   a_r7_ntsc_burst_axis: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_gate && !sync_lvl && !std_pal) |=> ##1
         (chroma_out == '0 || chroma_out == NS_POS || chroma_out == NS_NEG));
endmodule

bind rgb_composite_enc rgb_composite_enc_chk #(
   .IN_W(IN_W), .OUT_W(OUT_W), .FRAC(FRAC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .red        (red),
   .green      (green),
   .blue       (blue),
   .sync_lvl   (sync_lvl),
   .burst_gate (burst_gate),
   .std_pal    (std_pal),
   .luma_out   (luma_out),
   .chroma_out (chroma_out),
   .comp_out   (comp_out)
);

// File: tb/rgb_composite_enc_test.sv
module rgb_composite_enc_test;
   logic              clk = 1'b0;
   logic              rst_n = 1'b1;
   logic [7:0]        red = '0, green = '0, blue = '0;
   logic              sync_lvl = 1'b0, burst_gate = 1'b0, line_tgl = 1'b0, std_pal = 1'b0;
   logic signed [11:0] luma_out, chroma_out, comp_out;

   int total = 0;
   int bad = 0;
   int edges = 0;
   int base = 0;
   bit finished = 1'b0;

   typedef struct {
      int    due;
      int    luma;
      int    chroma;
      int    comp;
      string tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   rgb_composite_enc uut (
      .clk(clk), .rst_n(rst_n), .red(red), .green(green), .blue(blue),
      .sync_lvl(sync_lvl), .burst_gate(burst_gate), .line_tgl(line_tgl),
      .std_pal(std_pal), .luma_out(luma_out), .chroma_out(chroma_out),
      .comp_out(comp_out)
   );

   task automatic check(input string tag, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // reference model built from the requirement text
   task automatic model(input int r, input int g, input int b, input bit s, input bit gt,
                        input bit pal, input bit flp, input int ph,
                        output int l, output int c, output int cp);
      int y, u, v, uu, vv;
      y = (306 * r + 601 * g + 117 * b + 512) >>> 10;
      u = (505 * (b - y) + 512) >>> 10;
      v = (898 * (r - y) + 512) >>> 10;
      if (s) begin
         l = pal ? -107 : -102;
         uu = 0; vv = 0;
      end else begin
         l = y;
         if (gt) begin
            uu = pal ? -76 : -102;
            vv = pal ? 76 : 0;
         end else begin
            uu = u; vv = v;
         end
      end
      if (pal && flp) vv = -vv;
      case (ph)
         0: c = vv;
         1: c = uu;
         2: c = -vv;
         default: c = -uu;
      endcase
      cp = l + c;
      if (cp > 2047) cp = 2047;
      if (cp < -2048) cp = -2048;
   endtask

   task automatic drive(input int r, input int g, input int b, input bit s, input bit gt,
                        input bit pal, input bit flp, input string tag);
      exp_t e;
      int ph;
      @(negedge clk);
      red = 8'(r); green = 8'(g); blue = 8'(b);
      sync_lvl = s; burst_gate = gt; std_pal = pal; line_tgl = flp;
      ph = (edges - base) % 4;
      model(r, g, b, s, gt, pal, flp, ph, e.luma, e.chroma, e.comp);
      e.due = edges + 2;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic hold(input int r, input int g, input int b, input bit s, input bit gt,
                       input bit pal, input bit flp, input int n, input string tag);
      for (int i = 0; i < n; i++) drive(r, g, b, s, gt, pal, flp, tag);
   endtask

   // monitor: pops expected items when their outputs are due
   initial begin
      forever begin
         @(posedge clk);
         edges++;
         #2;
         while (sb.size() > 0 && sb[0].due <= edges) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "luma", int'(luma_out), e.luma);
            check(e.tag, "chroma", int'(chroma_out), e.chroma);
            check(e.tag, "composite R10", int'(comp_out), e.comp);
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1 rst_n = 1'b0;
      red = 8'd200; green = 8'd40; blue = 8'd90;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "luma", int'(luma_out), 0);
      check("R1", "chroma", int'(chroma_out), 0);
      check("R1", "composite", int'(comp_out), 0);
      red = '0; green = '0; blue = '0;
      @(negedge clk);
      rst_n = 1'b1;
      base = edges;

      // NTSC active video
      hold(255, 255, 255, 0, 0, 0, 0, 4, "R2 full scale");
      hold(0, 0, 0, 0, 0, 0, 0, 4, "R2 black");
      hold(255, 0, 0, 0, 0, 0, 0, 4, "R3 red");
      hold(0, 0, 255, 0, 0, 0, 0, 4, "R4 blue phases");
      hold(0, 255, 0, 0, 0, 0, 0, 4, "R10 green");
      hold(100, 100, 100, 0, 0, 0, 0, 4, "R5 grey");
      hold(255, 0, 0, 0, 0, 0, 1, 4, "R9 ntsc toggle ignored");
      // NTSC blanking
      hold(200, 50, 10, 1, 0, 0, 0, 4, "R6 ntsc sync");
      hold(200, 50, 10, 0, 1, 0, 0, 4, "R7 ntsc burst");
      hold(200, 50, 10, 1, 1, 0, 0, 4, "R11 sync over gate");
      // PAL
      hold(30, 220, 140, 1, 0, 1, 0, 4, "R6 pal sync");
      hold(30, 220, 140, 0, 1, 1, 0, 4, "R8 pal burst 135");
      hold(30, 220, 140, 0, 1, 1, 1, 4, "R8 pal burst 225");
      for (int ln = 0; ln < 6; ln++)
         hold(255, 0, 0, 0, 0, 1, ln[0], 4, "R9 pal line flip");
      hold(255, 255, 0, 1, 1, 1, 1, 4, "R11 pal sync over gate");
      // assorted colors in both standards
      for (int i = 0; i < 24; i++)
         drive(i * 11, 255 - i * 9, (i * 37) % 256, 0, 0, i[0], i[1], "R3 sweep");
      hold(0, 0, 0, 0, 0, 0, 0, 4, "R2 drain");
      repeat (4) @(negedge clk);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule